// File: doc/BRIEF.md
# SD Host Status and Error Flag Register

This block gathers the event pulses that the command and data engines of an SD/MMC host controller produce, and keeps them in two sticky status words. Each status word has its own mask register. Software clears a flag by writing a zero to its bit position. Writing a one leaves the flag as it is. An interrupt line is asserted while any flag is set and not masked.

The second status word also holds the two buffer-ready flags. Each one is set by the rising edge of a level from the data engine, so it records one event per block. Software can clear the flag before it drains the buffer, and the next block's edge is still captured. The error flags in the second word are reduced to a single error class under a fixed priority.

A live command-busy bit is shown in the second word. A command issue that arrives while the engine is busy is rejected on the next cycle instead of being accepted.

Top module: `sdst_status_regs`

## Requirements
- R1: After reset both flag words read 0, both mask words read 0xFFFF, `irq` is 0, `err_class` is 0 and `cmd_accept`/`cmd_reject` are 0.
- R2: A one-cycle pulse on `evt_a` bit 0 (response received), bit 2 (access complete) or bit 4 (card detect) sets that flag in word A, where it stays until cleared. Every other bit of word A always reads 0.
- R3: A register write to a flag word clears each flag whose `wr_data` bit is 0. Flags whose `wr_data` bit is 1 are unchanged, so writing 0xFFFF has no effect.
- R4: When a set event and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R5: Word B bit 8 (buffer read ready) and bit 9 (buffer write ready) are set only on a rising edge of `rd_ready_lvl` / `wr_ready_lvl`. If the level is held high after the flag has been cleared, the flag is not set again. A new rising edge sets it again. `evt_b` bits 8 and above have no effect.
- R6: `irq` is 1 exactly when some flag in either word is set and its mask bit is 0. A mask bit of 1 disables that flag.
- R7: `err_class` follows word B: 1 if the response timeout flag (bit 0) is set. Otherwise 2 if the data timeout flag (bit 4) is set. Otherwise 3 if any sync error flag is set (CRC bit 1, end bit bit 2, index bit 3). Otherwise 4 if any illegal access flag is set (address bit 5, read bit 6, write bit 7). Otherwise 0.
- R8: Word B bit 14 reads the live value of `engine_busy`. A write to word B does not change it.
- R9: A `cmd_issue` in a cycle where `engine_busy` is 1 gives `cmd_reject`=1 and `cmd_accept`=0 in the next cycle. When `engine_busy` is 0, the issue gives `cmd_accept`=1 and `cmd_reject`=0 in the next cycle.
- R10: `rd_sel`/`wr_sel` encoding: 0 = flag word A, 1 = mask word A, 2 = flag word B, 3 = mask word B. A write to a mask word stores all 16 bits of `wr_data`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_a | input | 16 | Set pulses for word A flags |
| evt_b | input | 16 | Set pulses for word B error flags (bits 7..0) |
| rd_ready_lvl | input | 1 | Buffer read ready level from data engine |
| wr_ready_lvl | input | 1 | Buffer write ready level from data engine |
| engine_busy | input | 1 | Live command engine busy |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register write select |
| wr_data | input | 16 | Register write data |
| rd_sel | input | 2 | Register read select |
| rd_data | output | 16 | Selected register value |
| cmd_issue | input | 1 | Request to start a command |
| cmd_accept | output | 1 | Command accepted (registered) |
| cmd_reject | output | 1 | Command rejected as busy (registered) |
| irq | output | 1 | Unmasked flag pending |
| err_class | output | 3 | Prioritised error class |

## Verification
Word A is driven with single pulses, with all sixteen bits at once, and with clearing writes whose data bits are mixed. These patterns separate real flags from unimplemented bits, and clear-on-zero from clear-on-one. A pulse is also made to coincide with a clear of the same bit, which shows whether set or clear wins. The ready levels are held high over several cycles with a clear in between, and are then lowered and raised again. This tells edge capture apart from level following. The error flags are added from lowest to highest priority and then removed from the top, so each class transition exposes the priority order.

// File: rtl/sdst_pkg.sv
package sdst_pkg;

    localparam int W = 16;

    // word A flag positions
    localparam int A_RESP = 0;
    localparam int A_XFER = 2;
    localparam int A_CARD = 4;

    // word B flag positions
    localparam int B_RTO  = 0;
    localparam int B_CRC  = 1;
    localparam int B_END  = 2;
    localparam int B_IDX  = 3;
    localparam int B_DTO  = 4;
    localparam int B_ILA  = 5;
    localparam int B_ILR  = 6;
    localparam int B_ILW  = 7;
    localparam int B_BRE  = 8;
    localparam int B_BWE  = 9;
    localparam int B_BUSY = 14;

    localparam int ERR_BITS = B_ILW + 1;
    localparam int N_EDGE   = 2;

    localparam logic [W-1:0] A_IMPL = (W'(1) << A_RESP) | (W'(1) << A_XFER) | (W'(1) << A_CARD);
    localparam logic [W-1:0] B_EVT  = (W'(1) << ERR_BITS) - W'(1);
    localparam logic [W-1:0] B_IMPL = B_EVT | (W'(1) << B_BRE) | (W'(1) << B_BWE);

    typedef enum logic [2:0] {
        ERR_NONE     = 3'd0,
        ERR_RESP_TMO = 3'd1,
        ERR_DATA_TMO = 3'd2,
        ERR_SYNC     = 3'd3,
        ERR_ILLEGAL  = 3'd4
    } err_class_e;

    typedef enum logic [1:0] {
        SEL_FLAG_A = 2'd0,
        SEL_MASK_A = 2'd1,
        SEL_FLAG_B = 2'd2,
        SEL_MASK_B = 2'd3
    } reg_sel_e;

    function automatic err_class_e classify(input logic [ERR_BITS-1:0] f);
        if (f[B_RTO])
            return ERR_RESP_TMO;
        else if (f[B_DTO])
            return ERR_DATA_TMO;
        else if (f[B_CRC] || f[B_END] || f[B_IDX])
            return ERR_SYNC;
        else if (f[B_ILA] || f[B_ILR] || f[B_ILW])
            return ERR_ILLEGAL;
        else
            return ERR_NONE;
    endfunction

endpackage

// File: rtl/sdst_flag_word.sv
module sdst_flag_word #(
    parameter int              WIDTH = 16,
    parameter logic [WIDTH-1:0] IMPL = '1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] set_in,
    input  logic             clr_we,
    input  logic             mask_we,
    input  logic [WIDTH-1:0] wr_data,
    output logic [WIDTH-1:0] flags,
    output logic [WIDTH-1:0] mask,
    output logic             pend
);
    logic [WIDTH-1:0] set_v;
    logic [WIDTH-1:0] kept;
    logic [WIDTH-1:0] flags_n;

    always_comb begin
        set_v   = set_in & IMPL;
        kept    = clr_we ? (flags & wr_data) : flags;
        flags_n = (kept | set_v) & IMPL;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '0;
            mask  <= '1;
        end else begin
            flags <= flags_n;
            if (mask_we)
                mask <= wr_data;
        end
    end

    assign pend = |(flags & ~mask);

    // R4
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (|(set_in & IMPL)) |=> ((flags & $past(set_in & IMPL)) == $past(set_in & IMPL)));

    // R3
    no_spont_chk: assert property (@(posedge clk) disable iff (rst)
        !(|(set_in & IMPL)) |=> ((flags & ~$past(flags)) == '0));

endmodule

// File: rtl/sdst_edge_set.sv
module sdst_edge_set #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] rise
);
    logic [N-1:0] prev;

    always_ff @(posedge clk) begin
        if (rst)
            prev <= '0;
        else
            prev <= lvl;
    end

    assign rise = lvl & ~prev;

    // R5
    rise_once_chk: assert property (@(posedge clk) disable iff (rst)
        (|rise) |=> ((rise & $past(rise)) == '0));

endmodule

// File: rtl/sdst_err_prio.sv
module sdst_err_prio
    import sdst_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [ERR_BITS-1:0] err_flags,
    output err_class_e          cls
);
    assign cls = classify(err_flags);

    // R7
    resp_first_chk: assert property (@(posedge clk) disable iff (rst)
        err_flags[B_RTO] |-> (cls == ERR_RESP_TMO));

    // R7
    none_clean_chk: assert property (@(posedge clk) disable iff (rst)
        (cls == ERR_NONE) |-> (err_flags == '0));

endmodule

// File: rtl/sdst_cmd_gate.sv
module sdst_cmd_gate (
    input  logic clk,
    input  logic rst,
    input  logic cmd_issue,
    input  logic busy,
    output logic cmd_accept,
    output logic cmd_reject
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_accept <= 1'b0;
            cmd_reject <= 1'b0;
        end else begin
            cmd_accept <= cmd_issue && !busy;
            cmd_reject <= cmd_issue && busy;
        end
    end

    // R9
    busy_block_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_issue && busy) |=> (cmd_reject && !cmd_accept));

    // R9
    excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(cmd_accept && cmd_reject));

endmodule

// File: rtl/sdst_status_regs.sv
module sdst_status_regs
    import sdst_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [15:0] evt_a,
    input  logic [15:0] evt_b,
    input  logic        rd_ready_lvl,
    input  logic        wr_ready_lvl,
    input  logic        engine_busy,
    input  logic        wr_en,
    input  logic [1:0]  wr_sel,
    input  logic [15:0] wr_data,
    input  logic [1:0]  rd_sel,
    output logic [15:0] rd_data,
    input  logic        cmd_issue,
    output logic        cmd_accept,
    output logic        cmd_reject,
    output logic        irq,
    output logic [2:0]  err_class
);
    logic [W-1:0]      flags_a, mask_a, flags_b, mask_b;
    logic [W-1:0]      set_b;
    logic [N_EDGE-1:0] rdy_rise;
    logic              pend_a, pend_b;
    err_class_e        cls;
    reg_sel_e          wsel, rsel;

    assign wsel = reg_sel_e'(wr_sel);
    assign rsel = reg_sel_e'(rd_sel);

    sdst_edge_set #(.N(N_EDGE)) u_edge (
        .clk  (clk),
        .rst  (rst),
        .lvl  ({wr_ready_lvl, rd_ready_lvl}),
        .rise (rdy_rise)
    );

    always_comb begin
        set_b        = evt_b & B_EVT;
        set_b[B_BRE] = rdy_rise[0];
        set_b[B_BWE] = rdy_rise[1];
    end

    sdst_flag_word #(.WIDTH(W), .IMPL(A_IMPL)) u_word_a (
        .clk     (clk),
        .rst     (rst),
        .set_in  (evt_a),
        .clr_we  (wr_en && wsel == SEL_FLAG_A),
        .mask_we (wr_en && wsel == SEL_MASK_A),
        .wr_data (wr_data),
        .flags   (flags_a),
        .mask    (mask_a),
        .pend    (pend_a)
    );

    sdst_flag_word #(.WIDTH(W), .IMPL(B_IMPL)) u_word_b (
        .clk     (clk),
        .rst     (rst),
        .set_in  (set_b),
        .clr_we  (wr_en && wsel == SEL_FLAG_B),
        .mask_we (wr_en && wsel == SEL_MASK_B),
        .wr_data (wr_data),
        .flags   (flags_b),
        .mask    (mask_b),
        .pend    (pend_b)
    );

    sdst_err_prio u_prio (
        .clk       (clk),
        .rst       (rst),
        .err_flags (flags_b[ERR_BITS-1:0]),
        .cls       (cls)
    );

    sdst_cmd_gate u_gate (
        .clk        (clk),
        .rst        (rst),
        .cmd_issue  (cmd_issue),
        .busy       (engine_busy),
        .cmd_accept (cmd_accept),
        .cmd_reject (cmd_reject)
    );

    always_comb begin
        unique case (rsel)
            SEL_FLAG_A: rd_data = flags_a;
            SEL_MASK_A: rd_data = mask_a;
            SEL_FLAG_B: begin
                rd_data         = flags_b;
                rd_data[B_BUSY] = engine_busy;
            end
            default:    rd_data = mask_b;
        endcase
    end

    assign irq       = pend_a || pend_b;
    assign err_class = cls;

    // R6
    irq_masked_chk: assert property (@(posedge clk) disable iff (rst)
        ((mask_a == '1) && (mask_b == '1)) |-> !irq);

    // R2
    a_unused_chk: assert property (@(posedge clk) disable iff (rst)
        (flags_a & ~A_IMPL) == '0);

endmodule

// File: tb/sdst_status_regs_tb.sv
module sdst_status_regs_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] evt_a = '0, evt_b = '0;
    logic        rd_ready_lvl = 1'b0, wr_ready_lvl = 1'b0, engine_busy = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = '0, rd_sel = '0;
    logic [15:0] wr_data = '0;
    logic        cmd_issue = 1'b0;
    logic [15:0] rd_data;
    logic        cmd_accept, cmd_reject, irq;
    logic [2:0]  err_class;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    sdst_status_regs u_dut (
        .clk(clk), .rst(rst), .evt_a(evt_a), .evt_b(evt_b),
        .rd_ready_lvl(rd_ready_lvl), .wr_ready_lvl(wr_ready_lvl),
        .engine_busy(engine_busy), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
        .cmd_issue(cmd_issue), .cmd_accept(cmd_accept), .cmd_reject(cmd_reject),
        .irq(irq), .err_class(err_class)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference model
    logic [15:0] m_fa, m_ma, m_fb, m_mb;
    logic        m_pr, m_pw, m_acc, m_rej;

    function automatic int m_class(input logic [15:0] f);
        if (f[0]) return 1;
        if (f[4]) return 2;
        if (f[3:1] != 0) return 3;
        if (f[7:5] != 0) return 4;
        return 0;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_fa = '0; m_fb = '0; m_ma = 16'hFFFF; m_mb = 16'hFFFF;
            m_pr = 0; m_pw = 0; m_acc = 0; m_rej = 0;
        end else begin
            logic [15:0] sa, sb;
            sa = evt_a & 16'h0015;
            sb = evt_b & 16'h00FF;
            if (rd_ready_lvl && !m_pr) sb[8] = 1'b1;
            if (wr_ready_lvl && !m_pw) sb[9] = 1'b1;
            if (wr_en && wr_sel == 2'd0) m_fa = m_fa & wr_data;
            if (wr_en && wr_sel == 2'd1) m_ma = wr_data;
            if (wr_en && wr_sel == 2'd2) m_fb = m_fb & wr_data & 16'h03FF;
            if (wr_en && wr_sel == 2'd3) m_mb = wr_data;
            m_fa = m_fa | sa;
            m_fb = m_fb | sb;
            m_pr = rd_ready_lvl; m_pw = wr_ready_lvl;
            m_acc = cmd_issue && !engine_busy;
            m_rej = cmd_issue && engine_busy;
        end
        #2;
        begin
            logic [15:0] exp_rd;
            case (rd_sel)
                2'd0: exp_rd = m_fa;
                2'd1: exp_rd = m_ma;
                2'd2: exp_rd = m_fb | (16'(engine_busy) << 14);
                default: exp_rd = m_mb;
            endcase
            chk("R10 model rd_data", int'(rd_data), int'(exp_rd));
            chk("R6 model irq", int'(irq), int'(((m_fa & ~m_ma) != 0) || ((m_fb & ~m_mb) != 0)));
            chk("R7 model err_class", int'(err_class), m_class(m_fb));
            chk("R9 model accept", int'(cmd_accept), int'(m_acc));
            chk("R9 model reject", int'(cmd_reject), int'(m_rej));
        end
    end

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] sel, input logic [15:0] d);
        @(negedge clk); wr_en = 1; wr_sel = sel; wr_data = d;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic pulse_a(input logic [15:0] v);
        @(negedge clk); evt_a = v;
        @(negedge clk); evt_a = '0;
    endtask

    task automatic pulse_b(input logic [15:0] v);
        @(negedge clk); evt_b = v;
        @(negedge clk); evt_b = '0;
    endtask

    task automatic peek(input logic [1:0] sel, output logic [15:0] v);
        @(negedge clk); rd_sel = sel;
        @(posedge clk); #3; v = rd_data;
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [15:0] v;
        cyc(3);
        @(negedge clk); rst = 0;
        // R1
        peek(2'd1, v); chk("R1 mask A", v, 16'hFFFF);
        peek(2'd3, v); chk("R1 mask B", v, 16'hFFFF);
        peek(2'd0, v); chk("R1 flags A", v, 0);
        chk("R1 irq", irq, 0); chk("R1 class", err_class, 0);
        // R2
        pulse_a(16'h0015); peek(2'd0, v); chk("R2 word A set", v, 16'h0015);
        pulse_a(16'hFFFF); peek(2'd0, v); chk("R2 unimplemented bits", v, 16'h0015);
        // R3
        wr(2'd0, 16'hFFFE); peek(2'd0, v); chk("R3 clear bit0", v, 16'h0014);
        wr(2'd0, 16'hFFFF); peek(2'd0, v); chk("R3 write ones no effect", v, 16'h0014);
        // R4
        @(negedge clk); wr_en = 1; wr_sel = 2'd0; wr_data = 16'h0000; evt_a = 16'h0001;
        @(negedge clk); wr_en = 0; evt_a = '0;
        peek(2'd0, v); chk("R4 set wins", v, 16'h0001);
        // R6
        chk("R6 masked no irq", irq, 0);
        wr(2'd1, 16'hFFFE); peek(2'd0, v); chk("R6 unmasked irq", irq, 1);
        wr(2'd0, 16'h0000); peek(2'd0, v); chk("R6 cleared irq", irq, 0);
        // R5
        @(negedge clk); rd_ready_lvl = 1;
        cyc(4); peek(2'd2, v); chk("R5 read ready set", v, 16'h0100);
        wr(2'd2, 16'h0000); cyc(3); peek(2'd2, v); chk("R5 held level no reset", v, 0);
        @(negedge clk); rd_ready_lvl = 0; cyc(2);
        @(negedge clk); rd_ready_lvl = 1; cyc(1);
        peek(2'd2, v); chk("R5 new edge sets", v, 16'h0100);
        @(negedge clk); rd_ready_lvl = 0; wr_ready_lvl = 1;
        cyc(2); peek(2'd2, v); chk("R5 write ready set", v, 16'h0300);
        @(negedge clk); wr_ready_lvl = 0;
        pulse_b(16'hFF00); wr(2'd2, 16'h0000);
        peek(2'd2, v); chk("R5 evt_b high bits ignored", v, 0);
        // R7
        pulse_b(16'h0080); peek(2'd2, v); chk("R7 illegal", err_class, 4);
        pulse_b(16'h0002); peek(2'd2, v); chk("R7 sync over illegal", err_class, 3);
        pulse_b(16'h0010); peek(2'd2, v); chk("R7 data timeout over sync", err_class, 2);
        pulse_b(16'h0001); peek(2'd2, v); chk("R7 response timeout first", err_class, 1);
        wr(2'd2, 16'hFFFE); peek(2'd2, v); chk("R7 drop rto", err_class, 2);
        wr(2'd2, 16'h0000); peek(2'd2, v); chk("R7 none", err_class, 0);
        // R8
        @(negedge clk); engine_busy = 1;
        peek(2'd2, v); chk("R8 busy bit live", v, 16'h4000);
        wr(2'd2, 16'h0000); peek(2'd2, v); chk("R8 write no effect", v, 16'h4000);
        // R9
        @(negedge clk); cmd_issue = 1;
        @(posedge clk); #3;
        chk("R9 reject while busy", cmd_reject, 1); chk("R9 no accept while busy", cmd_accept, 0);
        @(negedge clk); engine_busy = 0;
        @(posedge clk); #3;
        chk("R9 accept when idle", cmd_accept, 1); chk("R9 no reject when idle", cmd_reject, 0);
        @(negedge clk); cmd_issue = 0;
        // R10
        wr(2'd3, 16'h1234); peek(2'd3, v); chk("R10 mask B store", v, 16'h1234);
        peek(2'd1, v); chk("R10 mask A select", v, 16'hFFFE);
        cyc(4);
        finish_run();
    end
endmodule